// File: doc/BRIEF.md
# Self-Checking Systematic Cyclic Encoder

This block turns a 7-bit information word into a 15-bit codeword of a (15,7) cyclic code with minimum distance 5. The code is generated by g(x) = 1 + x^4 + x^6 + x^7 + x^8. The codeword is systematic: the information bits pass through unchanged into the low positions. The eight parity bits above them are the remainder of x^8·i(x) divided by g(x). A parallel XOR network forms the parity. A separate checker recomputes the syndrome of each produced word in a different, serial form.

An encode result is released only when its syndrome is all zeros. When the syndrome is nonzero, the block repeats the encode on the next cycle. After three repeats that all fail, it stops and raises a sticky fault flag. A test input XORs a mask into the parity network output, so a transient or persistent fault in the network can be imitated. The block takes words through a valid/ready handshake and returns each codeword with a one-cycle valid strobe.

Top module: `selfcheck_cyclic_enc`

## Requirements
- R1: In every released codeword, bits [6:0] equal the accepted information word, with information bit j placed in codeword bit j.
- R2: Codeword bits [14:7] hold the parity p[7:0]. Coefficient x^j of (x^8·i(x) mod g(x)) goes to p[j], with g(x) = 1+x^4+x^6+x^7+x^8. Examples of info→parity: 0x01→0xD1, 0x40→0xE8, 0x03→0xA2, 0x55→0xE5, 0x2A→0x1A, 0x7F→0xFF.
- R3: A word is accepted on a rising edge where in_valid and in_ready are both high. With no fault, out_valid is high for exactly one cycle, starting at the next rising edge.
- R4: in_ready is low from the edge after an accept until the codeword is released. It is high whenever the block is idle and not faulted.
- R5: Each check that finds a nonzero syndrome repeats the encode one cycle later and produces a one-cycle enc_retry pulse. Once the fault clears, the correct codeword is released one cycle after the first clean check.
- R6: If the first attempt and three repeats all fail (four failing checks), enc_fault rises at the fourth check edge. No codeword is released. enc_fault stays high, and in_ready stays low, until reset.
- R7: out_valid is asserted only for a word whose syndrome is zero, that is, whose parity field matches R2 for its information field.
- R8: While rst_n is low, and after its release, out_valid, enc_retry and enc_fault are 0, out_cw is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Information word offered |
| in_ready | output | 1 | Block can accept a word |
| in_info | input | 7 | Information word |
| tst_mask | input | 8 | Test mask XORed into the parity network output |
| out_valid | output | 1 | One-cycle strobe: out_cw holds a checked codeword |
| out_cw | output | 15 | Codeword: parity in [14:7], information in [6:0] |
| enc_retry | output | 1 | Pulse: a check failed and the encode is being repeated |
| enc_fault | output | 1 | Sticky: the retry budget ran out |

## Verification
The accept edge counts as check 1's reference. The codeword and out_valid are due at the edge after the accept. Each failed check delays the release by one cycle and shows an enc_retry pulse in that cycle. On the fourth consecutive failure, enc_fault replaces the release at that same edge. The bench drives inputs and samples outputs on the falling edge. After each rising edge it counts the checks elapsed, so every result is compared in the exact cycle it is due. It also confirms that out_valid has dropped one cycle later.

// File: rtl/enc_pkg.sv
// Package: shared parameters, state type and the column function of the
// systematic generator. Assumes the generator polynomial has degree PAR_W.
package enc_pkg;
    parameter int unsigned INFO_W    = 7;
    parameter int unsigned PAR_W     = 8;
    parameter int unsigned CW_W      = INFO_W + PAR_W;
    parameter int unsigned RETRY_MAX = 3;
    // g(x) without its leading x^8 term: 1 + x^4 + x^6 + x^7
    parameter logic [PAR_W-1:0] GEN_LOW = 8'hD1;
    localparam int unsigned CNT_W = $clog2(RETRY_MAX + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FAULT = 2'd2
    } enc_state_t;

    // remainder of x^(PAR_W + j) modulo g(x): generator column for info bit j
    function automatic logic [PAR_W-1:0] col_rem(input int unsigned j);
        logic [PAR_W-1:0] r;
        r = GEN_LOW;
        for (int unsigned s = 0; s < j; s++) begin
            r = {r[PAR_W-2:0], 1'b0} ^ (r[PAR_W-1] ? GEN_LOW : '0);
        end
        return r;
    endfunction
endpackage

// File: rtl/enc_parity_net.sv
// Parallel parity network: XOR of the generator columns selected by the
// information bits, then the test mask. Purely combinational.
module enc_parity_net
    import enc_pkg::*;
(
    input  logic [INFO_W-1:0] info,
    input  logic [PAR_W-1:0]  mask,
    output logic [PAR_W-1:0]  parity
);
    logic [PAR_W-1:0] term [INFO_W];

    // one gated column per information bit
    for (genvar j = 0; j < INFO_W; j++) begin : g_col
        localparam logic [PAR_W-1:0] COL = col_rem(j);
        assign term[j] = info[j] ? COL : '0;
    end

    // reduce the gated columns and apply the injected mask
    always_comb begin
        logic [PAR_W-1:0] acc;
        acc = mask;
        for (int j = 0; j < INFO_W; j++) acc = acc ^ term[j];
        parity = acc;
    end
endmodule

// File: rtl/enc_syndrome.sv
// Syndrome checker: re-derives the parity with a serial division
// (shift-register form, unrolled) and compares it to the parity field.
// Assumes codeword layout {parity, info}.
module enc_syndrome
    import enc_pkg::*;
(
    input  logic [CW_W-1:0]  cw,
    output logic [PAR_W-1:0] synd,
    output logic             clean
);
    // divide x^PAR_W * info(x) by g(x), most significant bit first
    always_comb begin
        logic [PAR_W-1:0] rem;
        logic             fb;
        rem = '0;
        for (int j = INFO_W - 1; j >= 0; j--) begin
            fb  = rem[PAR_W-1] ^ cw[j];
            rem = {rem[PAR_W-2:0], 1'b0} ^ (fb ? GEN_LOW : '0);
        end
        synd  = rem ^ cw[CW_W-1:INFO_W];
        clean = (synd == '0);
    end
endmodule

// File: rtl/enc_ctrl.sv
// Detect-and-repeat control: accepts a word, checks each encode once per
// cycle, repeats on a dirty syndrome up to RETRY_MAX times, then locks
// in a sticky fault state until reset.
module enc_ctrl
    import enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic synd_clean,
    output logic in_ready,
    output logic accept,
    output logic emit,
    output logic out_valid,
    output logic retry,
    output logic fault
);
    enc_state_t       state;
    logic [CNT_W-1:0] cnt;

    // handshake and release decode
    always_comb begin
        in_ready = (state == ST_IDLE);
        accept   = in_ready && in_valid;
        emit     = (state == ST_CHECK) && synd_clean;
    end

    // state, retry count and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            out_valid <= 1'b0;
            retry     <= 1'b0;
            fault     <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            retry     <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_CHECK;
                        cnt   <= '0;
                    end
                end
                ST_CHECK: begin
                    if (synd_clean) begin
                        out_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (cnt == CNT_W'(RETRY_MAX)) begin
                        fault <= 1'b1;
                        state <= ST_FAULT;
                    end else begin
                        cnt   <= cnt + 1'b1;
                        retry <= 1'b1;
                    end
                end
                default: state <= ST_FAULT;
            endcase
        end
    end
endmodule

// File: rtl/selfcheck_cyclic_enc.sv
// Top: latches the accepted word, encodes it through the parity network,
// verifies the result with the syndrome checker and registers the
// codeword only when the syndrome is zero.
module selfcheck_cyclic_enc
    import enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INFO_W-1:0] in_info,
    input  logic [PAR_W-1:0]  tst_mask,
    output logic              out_valid,
    output logic [CW_W-1:0]   out_cw,
    output logic              enc_retry,
    output logic              enc_fault
);
    logic [INFO_W-1:0] info_q;
    logic [PAR_W-1:0]  par;
    logic [PAR_W-1:0]  synd;
    logic [CW_W-1:0]   cw_now;
    logic              clean, accept, emit;

    enc_parity_net u_par (.info(info_q), .mask(tst_mask), .parity(par));

    assign cw_now = {par, info_q};

    enc_syndrome u_syn (.cw(cw_now), .synd(synd), .clean(clean));

    enc_ctrl u_ctl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .synd_clean(clean),
        .in_ready(in_ready), .accept(accept), .emit(emit),
        .out_valid(out_valid), .retry(enc_retry), .fault(enc_fault)
    );

    // hold the accepted word for every encode attempt
    always_ff @(posedge clk) begin
        if (!rst_n)      info_q <= '0;
        else if (accept) info_q <= in_info;
    end

    // register the checked codeword on release
    always_ff @(posedge clk) begin
        if (!rst_n)    out_cw <= '0;
        else if (emit) out_cw <= cw_now;
    end
endmodule

// File: rtl/enc_check.sv
// Checker bound to the top: protocol and code properties at the ports.
module enc_check
    import enc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [INFO_W-1:0] in_info,
    input logic              out_valid,
    input logic [CW_W-1:0]   out_cw,
    input logic              enc_retry,
    input logic              enc_fault
);
    logic [INFO_W-1:0] last_info;

    // reference parity by polynomial long division, least significant first
    function automatic logic [PAR_W-1:0] ref_par(input logic [INFO_W-1:0] d);
        logic [PAR_W-1:0] acc, col;
        acc = '0;
        col = GEN_LOW;
        for (int j = 0; j < INFO_W; j++) begin
            if (d[j]) acc = acc ^ col;
            col = {col[PAR_W-2:0], 1'b0} ^ (col[PAR_W-1] ? GEN_LOW : '0);
        end
        return acc;
    endfunction

    // track the most recently accepted word
    always_ff @(posedge clk) begin
        if (!rst_n)                    last_info <= '0;
        else if (in_valid && in_ready) last_info <= in_info;
    end

    // R7
    cw_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cw[CW_W-1:INFO_W] == ref_par(out_cw[INFO_W-1:0])));
    // R1
    info_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cw[INFO_W-1:0] == last_info));
    // R3
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R4
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    // R6
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_fault |=> enc_fault);
    // R6
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_fault |-> (!in_ready && !out_valid));
    // R5
    retry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_retry |-> (!out_valid && !in_ready));
endmodule

bind selfcheck_cyclic_enc enc_check u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_info(in_info), .out_valid(out_valid), .out_cw(out_cw),
    .enc_retry(enc_retry), .enc_fault(enc_fault)
);

// File: tb/sim_selfcheck_cyclic_enc.sv
module sim_selfcheck_cyclic_enc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [6:0]  in_info = '0;
    logic [7:0]  tst_mask = '0;
    logic        out_valid;
    logic [14:0] out_cw;
    logic        enc_retry;
    logic        enc_fault;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    selfcheck_cyclic_enc u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_info(in_info), .tst_mask(tst_mask), .out_valid(out_valid),
        .out_cw(out_cw), .enc_retry(enc_retry), .enc_fault(enc_fault)
    );

    // {info, expected parity} from R2
    localparam logic [14:0] VEC [7] = '{
        {7'h00, 8'h00}, {7'h01, 8'hD1}, {7'h40, 8'hE8}, {7'h03, 8'hA2},
        {7'h55, 8'hE5}, {7'h2A, 8'h1A}, {7'h7F, 8'hFF}
    };

    function automatic logic [7:0] serial_par(input logic [6:0] d);
        logic [7:0] r;
        logic       fb;
        r = '0;
        for (int j = 6; j >= 0; j--) begin
            fb = r[7] ^ d[j];
            r  = {r[6:0], 1'b0} ^ (fb ? 8'hD1 : 8'h00);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // offer a word; the first nbad checks see mask; report checks and retries
    task automatic run_one(input logic [6:0] info, input int nbad, input logic [7:0] mask,
                           output int done, output int retries);
        @(negedge clk);
        in_valid = 1'b1;
        in_info  = info;
        tst_mask = (nbad > 0) ? mask : 8'h00;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        done = 0;
        retries = 0;
        while (1) begin
            if (done == 0) check(!in_ready, "R4 busy", int'(in_ready), 0);
            @(posedge clk);
            @(negedge clk);
            done++;
            if (enc_retry) retries++;
            tst_mask = (done < nbad) ? mask : 8'h00;
            if (out_valid || enc_fault || done > 8) break;
        end
    endtask

    initial begin
        int done, retries;
        // R8 reset state
        repeat (3) @(negedge clk);
        check(out_valid == 0 && enc_retry == 0 && enc_fault == 0, "R8 flags in reset",
              int'({out_valid, enc_retry, enc_fault}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1, "R8 ready", int'(in_ready), 1);
        check(out_cw == 0, "R8 out_cw", int'(out_cw), 0);

        // vector table: R1 R2 R3
        for (int v = 0; v < 7; v++) begin
            run_one(VEC[v][14:8], 0, 8'h00, done, retries);
            check(out_valid && done == 1, "R3 latency", done, 1);
            check(out_cw == {VEC[v][7:0], VEC[v][14:8]}, "R1/R2 codeword",
                  int'(out_cw), int'({VEC[v][7:0], VEC[v][14:8]}));
            @(negedge clk);
            check(!out_valid, "R3 pulse", int'(out_valid), 0);
            check(in_ready, "R4 ready again", int'(in_ready), 1);
        end

        // exhaustive against a serial model: R2 R7
        for (int i = 0; i < 128; i++) begin
            run_one(7'(i), 0, 8'h00, done, retries);
            check(out_valid && out_cw == {serial_par(7'(i)), 7'(i)}, "R2/R7 all words",
                  int'(out_cw), int'({serial_par(7'(i)), 7'(i)}));
        end

        // R5: one and three failing checks, then a clean one
        run_one(7'h55, 1, 8'h01, done, retries);
        check(retries == 1 && done == 2, "R5 one retry", retries * 16 + done, 16 + 2);
        check(out_valid && out_cw == {8'hE5, 7'h55}, "R5 codeword after retry",
              int'(out_cw), int'({8'hE5, 7'h55}));
        run_one(7'h2A, 3, 8'h80, done, retries);
        check(retries == 3 && done == 4, "R5 three retries", retries * 16 + done, 48 + 4);
        check(out_valid && out_cw == {8'h1A, 7'h2A} && !enc_fault, "R5/R7 last chance",
              int'(out_cw), int'({8'h1A, 7'h2A}));

        // R6: four failing checks
        run_one(7'h7F, 4, 8'h10, done, retries);
        check(enc_fault && !out_valid && done == 4, "R6 fault raised", done, 4);
        check(retries == 3, "R6 retry count", retries, 3);
        @(negedge clk);
        in_valid = 1'b1;
        in_info  = 7'h01;
        repeat (4) begin
            @(negedge clk);
            check(enc_fault && !in_ready && !out_valid, "R6 sticky",
                  int'({enc_fault, in_ready, out_valid}), 4);
        end
        in_valid = 1'b0;

        // R8: reset clears the fault
        rst_n = 1'b0;
        @(negedge clk);
        check(!enc_fault && out_cw == 0, "R8 fault cleared", int'(enc_fault), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready, "R8 ready after fault", int'(in_ready), 1);
        run_one(7'h40, 0, 8'h00, done, retries);
        check(out_valid && out_cw == {8'hE8, 7'h40}, "R1 after reset",
              int'(out_cw), int'({8'hE8, 7'h40}));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule